// File: doc/BRIEF.md
# Compare-and-Swap Sequencer

This block performs an atomic compare-and-swap in several steps. It uses a reserved load and a conditional store to a memory unit that tracks reservations. The block has no read-modify-write bus cycle. A client hands over a target address, a comparison value and a replacement value.

The sequencer then runs these steps:

1. It reads the target word with a reserved load.
2. It compares the returned word with the comparison value.
3. If the two differ, it ends the operation as a failure and issues no store.
4. If they match, it issues a conditional store of the replacement value. The memory unit answers the store with an ok bit. If that bit reports that the reservation was lost, the operation also ends as a failure.

The outcome is a single registered bit. A register file can capture it during the one-cycle completion pulse. If the operation fails, software is responsible for any retry.

Top module: `cas_sequencer`

## Requirements
- R1: After reset, `req_ready` is 1 and `done`, `success`, `ld_req_valid` and `st_req_valid` are 0.
- R2: A request is taken on a cycle where `req_valid` and `req_ready` are both 1. `req_ready` then stays 0 until the cycle after the `done` pulse. While it is 0, `req_valid` is ignored.
- R3: After a request is taken, one reserved load is raised on `ld_req_valid`, carrying the request address on `ld_req_addr`. Both are held steady until `ld_req_ready` is sampled 1.
- R4: If the loaded word differs from the comparison value in any bit, no store is issued and the operation completes with `success` = 0.
- R5: If the loaded word equals the comparison value, one conditional store is raised on `st_req_valid`, with the request address and the replacement value. Both are held steady until `st_req_ready` is sampled 1.
- R6: If the store response reports `st_rsp_ok` = 0, the operation completes with `success` = 0.
- R7: The operation completes with `success` = 1 only when the compare matched and the store response reports `st_rsp_ok` = 1.
- R8: `done` is high for exactly one cycle per operation. `success` is valid in that cycle and keeps its value until the next `done`.
- R9: Each operation issues exactly one load request and at most one store request. Load and store responses are accepted only after the matching request has been handed over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Client offers a compare-and-swap |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_addr | input | AW | Target address |
| req_cmp | input | DW | Comparison value |
| req_new | input | DW | Replacement value |
| ld_req_valid | output | 1 | Reserved load request |
| ld_req_ready | input | 1 | Memory takes the load request |
| ld_req_addr | output | AW | Load address |
| ld_rsp_valid | input | 1 | Load data returned |
| ld_rsp_data | input | DW | Loaded word |
| st_req_valid | output | 1 | Conditional store request |
| st_req_ready | input | 1 | Memory takes the store request |
| st_req_addr | output | AW | Store address |
| st_req_data | output | DW | Store data |
| st_rsp_valid | input | 1 | Store outcome returned |
| st_rsp_ok | input | 1 | 1 when the reservation held and the store was performed |
| done | output | 1 | One-cycle completion pulse |
| success | output | 1 | Registered outcome of the last operation |

## Verification
The assertions assume that the memory side raises `ld_rsp_valid` only after it has taken the load request and while the result is still awaited. The same applies to `st_rsp_valid` for the store. Each response is assumed to be a single-cycle pulse.

The bench acts as the memory unit inside each scenario task. It raises each response only after the handshake it has just completed, and holds each response for one cycle. It also stalls the request ready lines to exercise the hold rules.

// File: rtl/cas_pkg.sv
package cas_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LDW   = 3'd1,
    ST_CMP   = 3'd2,
    ST_STW   = 3'd3,
    ST_RESP  = 3'd4
  } cas_state_t;
endpackage

// File: rtl/cas_req_latch.sv
module cas_req_latch #(
  parameter int AW = 32,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] cmp_in,
  input  logic [DW-1:0] new_in,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] cmp_q,
  output logic [DW-1:0] new_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      cmp_q  <= '0;
      new_q  <= '0;
    end else if (load) begin
      addr_q <= addr_in;
      cmp_q  <= cmp_in;
      new_q  <= new_in;
    end
  end
endmodule

// File: rtl/cas_compare.sv
module cas_compare #(
  parameter int DW     = 64,
  parameter int LANE_W = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          capture,
  input  logic [DW-1:0] ld_data,
  input  logic [DW-1:0] cmp_val,
  output logic          match
);
  localparam int LANES = DW / LANE_W;
  logic [LANES-1:0] lane_eq;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_eq[g] = (ld_data[g*LANE_W +: LANE_W] == cmp_val[g*LANE_W +: LANE_W]);
  end

  always_ff @(posedge clk) begin
    if (rst)          match <= 1'b0;
    else if (capture) match <= &lane_eq;
  end

  initial assert (DW % LANE_W == 0) else $error("lane width must divide data width");
endmodule

// File: rtl/cas_ctrl.sv
module cas_ctrl
  import cas_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  output logic req_ready,
  output logic take_req,
  output logic ld_req_valid,
  input  logic ld_req_ready,
  input  logic ld_rsp_valid,
  output logic ld_capture,
  input  logic match,
  output logic st_req_valid,
  input  logic st_req_ready,
  input  logic st_rsp_valid,
  input  logic st_rsp_ok,
  output logic done,
  output logic success
);
  cas_state_t state_q;
  logic ld_sent_q, st_sent_q;

  assign take_req   = req_valid && req_ready;
  assign ld_capture = (state_q == ST_LDW) && ld_sent_q && ld_rsp_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      req_ready    <= 1'b1;
      ld_req_valid <= 1'b0;
      st_req_valid <= 1'b0;
      ld_sent_q    <= 1'b0;
      st_sent_q    <= 1'b0;
      done         <= 1'b0;
      success      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state_q)
        ST_IDLE: if (take_req) begin
          req_ready    <= 1'b0;
          ld_req_valid <= 1'b1;
          ld_sent_q    <= 1'b0;
          state_q      <= ST_LDW;
        end
        ST_LDW: begin
          if (ld_req_valid && ld_req_ready) begin
            ld_req_valid <= 1'b0;
            ld_sent_q    <= 1'b1;
          end
          if (ld_capture) state_q <= ST_CMP;
        end
        ST_CMP: if (match) begin
          st_req_valid <= 1'b1;
          st_sent_q    <= 1'b0;
          state_q      <= ST_STW;
        end else begin
          done    <= 1'b1;
          success <= 1'b0;
          state_q <= ST_RESP;
        end
        ST_STW: begin
          if (st_req_valid && st_req_ready) begin
            st_req_valid <= 1'b0;
            st_sent_q    <= 1'b1;
          end
          if (st_sent_q && st_rsp_valid) begin
            done    <= 1'b1;
            success <= st_rsp_ok;
            state_q <= ST_RESP;
          end
        end
        ST_RESP: begin
          req_ready <= 1'b1;
          state_q   <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Taking a request closes the door at once.
  assert_busy_after_take_R2: assert property (@(posedge clk) disable iff (rst)
    take_req |=> !req_ready);
  // The door stays shut until the cycle after done.
  assert_ready_waits_done_R2: assert property (@(posedge clk) disable iff (rst)
    !req_ready && !done |=> !req_ready);
  assert_ld_hold_R3: assert property (@(posedge clk) disable iff (rst)
    ld_req_valid && !ld_req_ready |=> ld_req_valid);
  assert_st_hold_R5: assert property (@(posedge clk) disable iff (rst)
    st_req_valid && !st_req_ready |=> st_req_valid);
  assert_miss_no_store_R4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_CMP) && !match |=> !st_req_valid && done && !success);
  assert_store_fail_R6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_STW) && st_sent_q && st_rsp_valid && !st_rsp_ok |=> done && !success);
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_success_held_R8: assert property (@(posedge clk) disable iff (rst)
    !done |=> done || $stable(success));
  assert_one_load_R9: assert property (@(posedge clk) disable iff (rst)
    ld_req_valid && ld_req_ready |=> !ld_req_valid);
  assert_ldrsp_expected_R9: assert property (@(posedge clk) disable iff (rst)
    ld_rsp_valid |-> (state_q == ST_LDW) && ld_sent_q);
  assert_strsp_expected_R9: assert property (@(posedge clk) disable iff (rst)
    st_rsp_valid |-> (state_q == ST_STW) && st_sent_q);
endmodule

// File: rtl/cas_sequencer.sv
module cas_sequencer #(
  parameter int AW     = 32,
  parameter int DW     = 64,
  parameter int LANE_W = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_cmp,
  input  logic [DW-1:0] req_new,
  output logic          ld_req_valid,
  input  logic          ld_req_ready,
  output logic [AW-1:0] ld_req_addr,
  input  logic          ld_rsp_valid,
  input  logic [DW-1:0] ld_rsp_data,
  output logic          st_req_valid,
  input  logic          st_req_ready,
  output logic [AW-1:0] st_req_addr,
  output logic [DW-1:0] st_req_data,
  input  logic          st_rsp_valid,
  input  logic          st_rsp_ok,
  output logic          done,
  output logic          success
);
  logic          take_req, ld_capture, match;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] cmp_q, new_q;

  cas_req_latch #(.AW(AW), .DW(DW)) u_latch (
    .clk(clk), .rst(rst), .load(take_req),
    .addr_in(req_addr), .cmp_in(req_cmp), .new_in(req_new),
    .addr_q(addr_q), .cmp_q(cmp_q), .new_q(new_q)
  );

  cas_compare #(.DW(DW), .LANE_W(LANE_W)) u_cmp (
    .clk(clk), .rst(rst), .capture(ld_capture),
    .ld_data(ld_rsp_data), .cmp_val(cmp_q), .match(match)
  );

  cas_ctrl u_ctrl (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .take_req(take_req),
    .ld_req_valid(ld_req_valid), .ld_req_ready(ld_req_ready),
    .ld_rsp_valid(ld_rsp_valid), .ld_capture(ld_capture), .match(match),
    .st_req_valid(st_req_valid), .st_req_ready(st_req_ready),
    .st_rsp_valid(st_rsp_valid), .st_rsp_ok(st_rsp_ok),
    .done(done), .success(success)
  );

  assign ld_req_addr = addr_q;
  assign st_req_addr = addr_q;
  assign st_req_data = new_q;

  assert_addr_stable_R3: assert property (@(posedge clk) disable iff (rst)
    ld_req_valid && !ld_req_ready |=> $stable(ld_req_addr));
  assert_store_stable_R5: assert property (@(posedge clk) disable iff (rst)
    st_req_valid && !st_req_ready |=> $stable(st_req_data) && $stable(st_req_addr));
endmodule

// File: tb/cas_sequencer_tb.sv
module cas_sequencer_tb;
  localparam int AW = 32;
  localparam int DW = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 0, ld_req_ready = 0, ld_rsp_valid = 0;
  logic st_req_ready = 0, st_rsp_valid = 0, st_rsp_ok = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_cmp = '0, req_new = '0, ld_rsp_data = '0;
  logic req_ready, ld_req_valid, st_req_valid, done, success;
  logic [AW-1:0] ld_req_addr, st_req_addr;
  logic [DW-1:0] st_req_data;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  cas_sequencer #(.AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_cmp(req_cmp), .req_new(req_new),
    .ld_req_valid(ld_req_valid), .ld_req_ready(ld_req_ready), .ld_req_addr(ld_req_addr),
    .ld_rsp_valid(ld_rsp_valid), .ld_rsp_data(ld_rsp_data),
    .st_req_valid(st_req_valid), .st_req_ready(st_req_ready),
    .st_req_addr(st_req_addr), .st_req_data(st_req_data),
    .st_rsp_valid(st_rsp_valid), .st_rsp_ok(st_rsp_ok),
    .done(done), .success(success)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cyc++;
  endtask

  // One full operation with the bench acting as memory.
  task automatic run_cas(input logic [AW-1:0] a, input logic [DW-1:0] c, input logic [DW-1:0] n,
                         input logic [DW-1:0] memv, input bit ok, input int stall);
    bit hit = (memv == c);
    bit st_seen = 0;
    int ld_count = 0;
    int t;
    chk(req_ready == 1'b1, "R2 ready before request", {63'd0, req_ready}, 64'd1);
    req_valid = 1; req_addr = a; req_cmp = c; req_new = n;
    tick();
    req_valid = 0; req_addr = '0; req_cmp = '0; req_new = '0;
    chk(req_ready == 1'b0, "R2 busy after take", {63'd0, req_ready}, 64'd0);
    // Load request with stall
    t = 0;
    while (!ld_req_valid && t < 20) begin tick(); t++; end
    chk(ld_req_valid && ld_req_addr == a, "R3 load addr", {32'd0, ld_req_addr}, {32'd0, a});
    // A second request offered while busy must be refused.
    req_valid = 1; req_addr = ~a;
    for (int i = 0; i < stall; i++) begin
      tick();
      chk(ld_req_valid && ld_req_addr == a, "R3 load held in stall", {32'd0, ld_req_addr}, {32'd0, a});
      chk(req_ready == 1'b0, "R2 refused while busy", {63'd0, req_ready}, 64'd0);
    end
    req_valid = 0; req_addr = '0;
    ld_req_ready = 1;
    tick();
    ld_count++;
    ld_req_ready = 0;
    chk(ld_req_valid == 1'b0, "R9 single load", {63'd0, ld_req_valid}, 64'd0);
    tick();
    ld_rsp_valid = 1; ld_rsp_data = memv;
    tick();
    ld_rsp_valid = 0; ld_rsp_data = '0;
    // Wait for store or completion
    t = 0;
    while (!done && t < 40) begin
      if (ld_req_valid) ld_count++;
      if (st_req_valid && !st_seen) begin
        st_seen = 1;
        chk(st_req_addr == a && st_req_data == n, "R5 store addr/data", st_req_data, n);
        st_req_ready = 0;
        tick();
        chk(st_req_valid && st_req_data == n, "R5 store held in stall", {63'd0, st_req_valid}, 64'd1);
        st_req_ready = 1;
        tick();
        st_req_ready = 0;
        chk(st_req_valid == 1'b0, "R9 single store", {63'd0, st_req_valid}, 64'd0);
        tick();
        st_rsp_valid = 1; st_rsp_ok = ok;
        tick();
        st_rsp_valid = 0; st_rsp_ok = 0;
      end else begin
        tick();
      end
      t++;
    end
    chk(done == 1'b1, "R8 done seen", {63'd0, done}, 64'd1);
    chk(st_seen == hit, hit ? "R5 store issued on match" : "R4 no store on mismatch",
        {63'd0, st_seen}, {63'd0, hit});
    chk(ld_count == 1, "R9 load count", ld_count, 1);
    chk(success == (hit && ok), hit ? (ok ? "R7 success" : "R6 store fail") : "R4 compare fail",
        {63'd0, success}, {63'd0, (hit && ok)});
    tick();
    chk(done == 1'b0, "R8 done one cycle", {63'd0, done}, 64'd0);
    chk(req_ready == 1'b1, "R2 ready after done", {63'd0, req_ready}, 64'd1);
    tick(); tick();
    chk(success == (hit && ok), "R8 success held", {63'd0, success}, {63'd0, (hit && ok)});
  endtask

  task automatic test_reset();
    chk(req_ready == 1'b1 && done == 0 && success == 0 && ld_req_valid == 0 && st_req_valid == 0,
        "R1 reset state", {59'd0, req_ready, done, success, ld_req_valid, st_req_valid}, 64'h10);
  endtask

  initial begin
    repeat (3) tick();
    rst = 0;
    tick();
    test_reset();
    run_cas(32'h1000, 64'hDEAD_BEEF_0000_0001, 64'h1111, 64'hDEAD_BEEF_0000_0001, 1, 2); // R7
    run_cas(32'h2000, 64'h5, 64'h6, 64'h5, 0, 0);                                   // R6
    run_cas(32'h3000, 64'hAAAA, 64'hBBBB, 64'hAAAB, 1, 1);                          // R4 low bit
    run_cas(32'h4000, 64'h8000_0000_0000_0000, 64'h1, 64'h0, 1, 0);                 // R4 top bit
    run_cas(32'h5000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 1, 3); // R7 all ones
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(5 * 100000);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule